// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point numbers and returns their sum in the same 32-bit format. Each word holds a sign bit in bit 31, an 8-bit exponent in bits 30:23 with a bias of 127, and a 23-bit fraction in bits 22:0. Normal numbers carry an implicit leading one in front of the fraction. An exponent of 255 with a zero fraction is an infinity, signed by bit 31. An exponent of 255 with a non-zero fraction is a NaN.

A caller presents both operands with `in_valid` high for one cycle. The sum appears one clock later, held in an output register and marked by `out_valid`. The datapath is a single combinational pass. It splits each operand into fields and restores the hidden one. It orders the operands by magnitude and right-shifts the smaller mantissa by the exponent gap, keeping guard, round and sticky bits. It then adds or subtracts the mantissas according to the signs. After that it normalises through a leading-zero count or a one-place right shift, rounds to nearest with ties going to even, and packs the fields back into a word. Denormal operands and results are flushed to zero, and no exception flags are produced.

Top module: `fp32_adder`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `sum` is 0x00000000.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `sum` holds the result for those operands. When `in_valid` is low at a rising edge, `out_valid` is low after it.
- R3: Two finite operands with the same sign give the correctly rounded sum, for example 1.0 + 1.0 = 0x40000000 and 3.0 + 1.0 = 0x40800000.
- R4: The smaller operand is aligned with guard, round and sticky bits, and every bit shifted past the round position counts toward sticky. An exponent gap of 26 or more leaves only sticky set, so 1.0 + 2^-30 = 0x3F800000, while 1.0 + 0x33800001 = 0x3F800001.
- R5: With opposite signs, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger. An exact zero difference gives +0 (0x00000000).
- R6: Rounding is to nearest with ties to even. A carry out of rounding renormalises the result and increments the exponent, so 0x3F800001 + 0x33800000 = 0x3F800002 and 0x3FFFFFFF + 0x33800000 = 0x40000000.
- R7: After a subtraction, the result is shifted left by its leading-zero count and the exponent drops by the same amount. If the exponent reaches 0 or below, the result is a zero carrying the larger operand's sign. A result with exponent 0 and a non-zero fraction never appears.
- R8: A result exponent of 255 or more, reached in normalisation or in rounding, gives an infinity with the result's sign (0x7F800000 or 0xFF800000).
- R9: An operand whose exponent field is 0 is treated as zero whatever its fraction. Zero plus a normal value returns that value unchanged. Zero plus zero gives 0x80000000 only when both signs are 1, and 0x00000000 otherwise.
- R10: Any NaN operand, or the sum of two infinities of opposite sign, gives 0x7FC00000.
- R11: An infinity plus a finite value, or plus an infinity of the same sign, returns that infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `op_a` and `op_b` are to be added |
| op_a | input | 32 | First operand, single-precision word |
| op_b | input | 32 | Second operand, single-precision word |
| out_valid | output | 1 | `sum` holds a new result |
| sum | output | 32 | Registered single-precision sum |

## Verification
Every result, whether special-case, rounded, flushed or overflowed, is due exactly one rising edge after the edge that samples `in_valid`. No input combination takes a longer path. The bench evaluates a behavioural model at the same edge the design captures its operands, and holds the expected word and its requirement tag in a one-entry register. It then compares `out_valid` and `sum` at the following falling edge, when the outputs are stable. Idle cycles between bursts confirm that `out_valid` drops one edge after `in_valid` does, and back-to-back bursts confirm that each result is tied to its own operands.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int MANT_W  = FRAC_W + 1;           // hidden one restored
    localparam int EXT_W   = MANT_W + 3;           // guard, round, sticky
    localparam int SUM_W   = EXT_W + 1;            // carry out of the add
    localparam int LZ_W    = $clog2(EXT_W + 1);
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int ALIGN_LIM = EXT_W - 1;          // gap that leaves only sticky

    localparam logic [WORD_W-1:0] QNAN_BITS =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              is_zero;
        logic              is_inf;
        logic              is_nan;
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
    } fp_unp_t;

    function automatic logic [WORD_W-1:0] make_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] make_zero(input logic s);
        return {s, {(WORD_W-1){1'b0}}};
    endfunction

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            found;
        n     = LZ_W'(EXT_W);
        found = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!found && v[i]) begin
                n     = LZ_W'(EXT_W - 1 - i);
                found = 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_unp_t           unp
);
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;

    always_comb begin
        e           = word[WORD_W-2 -: EXP_W];
        f           = word[FRAC_W-1:0];
        unp.sign    = word[WORD_W-1];
        unp.exp     = e;
        unp.mant    = {1'b1, f};
        unp.is_zero = (e == '0);
        unp.is_inf  = (e == '1) && (f == '0);
        unp.is_nan  = (e == '1) && (f != '0);
    end
endmodule

// File: rtl/fpadd_addsub.sv
module fpadd_addsub
    import fpadd_pkg::*;
(
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [MANT_W-1:0] a_mant,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [MANT_W-1:0] b_mant,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [SUM_W-1:0]  res_sum,
    output logic              res_zero
);
    localparam int WIDE_W = MANT_W + EXT_W - 1;
    localparam logic [EXP_W-1:0] GAP_LIM = EXP_W'(ALIGN_LIM);

    logic              a_big;
    logic [EXP_W-1:0]  big_exp, sml_exp, gap;
    logic [MANT_W-1:0] big_mant, sml_mant;
    logic [WIDE_W-1:0] shifted;
    logic [EXT_W-1:0]  big_ext, aligned;

    always_comb begin
        a_big    = {a_exp, a_mant} >= {b_exp, b_mant};
        big_exp  = a_big ? a_exp  : b_exp;
        big_mant = a_big ? a_mant : b_mant;
        sml_exp  = a_big ? b_exp  : a_exp;
        sml_mant = a_big ? b_mant : a_mant;
        res_sign = a_big ? a_sign : b_sign;
        res_exp  = big_exp;

        gap     = big_exp - sml_exp;
        shifted = {sml_mant, {(WIDE_W-MANT_W){1'b0}}} >> gap;
        if (gap >= GAP_LIM)
            aligned = {{(EXT_W-1){1'b0}}, 1'b1};
        else
            aligned = {shifted[WIDE_W-1 -: EXT_W-1], |shifted[WIDE_W-EXT_W:0]};

        big_ext = {big_mant, 3'b000};
        if (a_sign ^ b_sign)
            res_sum = {1'b0, big_ext} - {1'b0, aligned};
        else
            res_sum = {1'b0, big_ext} + {1'b0, aligned};
        res_zero = (res_sum == '0);
    end
endmodule

// File: rtl/fpadd_normround.sv
module fpadd_normround
    import fpadd_pkg::*;
(
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [SUM_W-1:0]  sum_in,
    output logic [WORD_W-1:0] word
);
    localparam int EW = EXP_W + 2;
    localparam logic signed [EW-1:0] S_ONE  = EW'(1);
    localparam logic signed [EW-1:0] S_ZERO = '0;
    localparam logic signed [EW-1:0] S_EMAX = EW'(EXP_MAX);

    logic [LZ_W-1:0]          lz;
    logic [EXT_W-1:0]         norm;
    logic signed [EW-1:0]     e_base, e_norm, e_rnd;
    logic [MANT_W-1:0]        keep;
    logic                     up;
    logic [MANT_W:0]          rnd;
    logic [FRAC_W-1:0]        frac_out;

    always_comb begin
        lz     = lead_zeros(sum_in[EXT_W-1:0]);
        e_base = $signed({{(EW-EXP_W){1'b0}}, exp_in});
        if (sum_in[SUM_W-1]) begin
            norm   = {sum_in[SUM_W-1:2], sum_in[1] | sum_in[0]};
            e_norm = e_base + S_ONE;
        end else begin
            norm   = sum_in[EXT_W-1:0] << lz;
            e_norm = e_base - $signed({{(EW-LZ_W){1'b0}}, lz});
        end

        keep = norm[EXT_W-1:3];
        up   = norm[2] & (norm[1] | norm[0] | norm[3]);
        rnd  = {1'b0, keep} + {{MANT_W{1'b0}}, up};
        if (rnd[MANT_W]) begin
            frac_out = rnd[FRAC_W:1];
            e_rnd    = e_norm + S_ONE;
        end else begin
            frac_out = rnd[FRAC_W-1:0];
            e_rnd    = e_norm;
        end

        if (e_norm <= S_ZERO)
            word = make_zero(sign);
        else if (e_rnd >= S_EMAX)
            word = make_inf(sign);
        else
            word = {sign, e_rnd[EXP_W-1:0], frac_out};
    end
endmodule

// File: rtl/fp32_adder.sv
module fp32_adder
    import fpadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] sum
);
    logic [WORD_W-1:0] ops [2];
    fp_unp_t           unp [2];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_unpack
        fpadd_unpack u_unpack (.word(ops[g]), .unp(unp[g]));
    end

    logic              as_sign, as_zero;
    logic [EXP_W-1:0]  as_exp;
    logic [SUM_W-1:0]  as_sum;
    logic [WORD_W-1:0] rounded, next_sum;

    fpadd_addsub u_addsub (
        .a_sign  (unp[0].sign), .a_exp(unp[0].exp), .a_mant(unp[0].mant),
        .b_sign  (unp[1].sign), .b_exp(unp[1].exp), .b_mant(unp[1].mant),
        .res_sign(as_sign), .res_exp(as_exp), .res_sum(as_sum), .res_zero(as_zero)
    );

    fpadd_normround u_normround (
        .sign(as_sign), .exp_in(as_exp), .sum_in(as_sum), .word(rounded)
    );

    always_comb begin
        if (unp[0].is_nan || unp[1].is_nan ||
            (unp[0].is_inf && unp[1].is_inf && (unp[0].sign != unp[1].sign)))
            next_sum = QNAN_BITS;
        else if (unp[0].is_inf)
            next_sum = make_inf(unp[0].sign);
        else if (unp[1].is_inf)
            next_sum = make_inf(unp[1].sign);
        else if (unp[0].is_zero && unp[1].is_zero)
            next_sum = make_zero(unp[0].sign & unp[1].sign);
        else if (unp[0].is_zero)
            next_sum = op_b;
        else if (unp[1].is_zero)
            next_sum = op_a;
        else if (as_zero)
            next_sum = make_zero(1'b0);
        else
            next_sum = rounded;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sum       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                sum <= next_sum;
        end
    end

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10
    nan_out_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (unp[0].is_nan || unp[1].is_nan)) |=> (sum == QNAN_BITS));
    // R11
    inf_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && unp[0].is_inf && !unp[1].is_inf && !unp[1].is_nan)
        |=> (sum == {$past(op_a[WORD_W-1]), {EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
    // R7
    no_denorm_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !((sum[WORD_W-2 -: EXP_W] == '0) && (sum[FRAC_W-1:0] != '0)));
    // R8
    inf_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (sum[WORD_W-2 -: EXP_W] == '1))
        |-> ((sum[FRAC_W-1:0] == '0) || (sum == QNAN_BITS)));
    // R5
    cancel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !unp[0].is_zero && !unp[1].is_zero &&
         (unp[0].exp != '1) && (unp[1].exp != '1) &&
         (op_a == (op_b ^ {1'b1, {(WORD_W-1){1'b0}}})))
        |=> (sum == '0));
endmodule

// File: tb/fp32_adder_tb.sv
module fp32_adder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        out_valid;
    logic [31:0] sum;

    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R3";
    logic        exp_valid = 1'b0;
    logic [31:0] exp_sum = '0;
    string       exp_tag = "R3";

    always #5 clk = ~clk;

    fp32_adder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .sum(sum)
    );

    function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b);
        int ea, eb, eg, es, sh, p, e;
        logic sg;
        longint unsigned mg, ms, bb, t, s, m, rem, half;
        ea = int'(a[30:23]); eb = int'(b[30:23]);
        if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return 32'h7FC00000;
        if (ea == 255 && eb == 255) return (a[31] == b[31]) ? a : 32'h7FC00000;
        if (ea == 255) return a;
        if (eb == 255) return b;
        if (ea == 0 && eb == 0) return {a[31] & b[31], 31'd0};
        if (ea == 0) return b;
        if (eb == 0) return a;
        if (a[30:0] >= b[30:0]) begin
            sg = a[31]; eg = ea; es = eb;
            mg = {40'd1, a[22:0]}; ms = {40'd1, b[22:0]};
        end else begin
            sg = b[31]; eg = eb; es = ea;
            mg = {40'd1, b[22:0]}; ms = {40'd1, a[22:0]};
        end
        sh = eg - es;
        bb = mg << 36;
        t  = (sh > 59) ? 64'd0 : ((ms << 35) >> sh);
        t  = (t << 1) | ((sh > 35) ? 64'd1 : 64'd0);
        s  = (a[31] != b[31]) ? bb - t : bb + t;
        if (s == 0) return 32'h00000000;
        p = -1;
        for (int i = 63; i >= 0; i--) if (s[i] && p < 0) p = i;
        e = eg + p - 59;
        if (e <= 0) return {sg, 31'd0};
        m    = s >> (p - 23);
        rem  = s & ((64'd1 << (p - 23)) - 1);
        half = 64'd1 << (p - 24);
        if (rem > half || (rem == half && m[0])) m = m + 1;
        if (m == (64'd1 << 24)) begin m = m >> 1; e = e + 1; end
        if (e >= 255) return {sg, 8'hFF, 23'd0};
        return {sg, e[7:0], m[22:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, expv);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            exp_valid <= 1'b0;
            exp_sum   <= '0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                exp_sum <= ref_add(op_a, op_b);
                exp_tag <= cur_tag;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R2 out_valid", {31'd0, out_valid}, {31'd0, exp_valid});
            if (exp_valid) check(exp_tag, sum, exp_sum);
        end
    end

    task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; op_a = 32'h7F800001; op_b = 32'h3F800000;
        end
    endtask

    function automatic logic [31:0] pick(input int ex, input logic s);
        return {s, ex[7:0], 23'($urandom)};
    endfunction

    initial begin
        #2000000;
        fails++;
        $display("FAIL R2 watchdog expired: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset sum", sum, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 first cycle sum", sum, 32'd0);

        send(32'h3F800000, 32'h3F800000, "R3 1+1");
        send(32'h40400000, 32'h3F800000, "R3 3+1");
        idle(2);
        send(32'h3F800000, 32'h30800000, "R4 gap over 26");
        send(32'h3F800000, 32'h33800001, "R4 sticky above half");
        send(32'h3F800000, 32'h33800000, "R6 tie to even low");
        send(32'h3F800001, 32'h33800000, "R6 tie to even up");
        send(32'h3FFFFFFF, 32'h33800000, "R6 round carry");
        idle(1);
        send(32'h3FC00000, 32'hBFC00000, "R5 cancel plus");
        send(32'hBFC00000, 32'h3FC00000, "R5 cancel minus");
        send(32'hC0400000, 32'h40000000, "R5 sign of larger");
        send(32'h3F800000, 32'hBF7FFFFF, "R7 leading zeros");
        send(32'h01000000, 32'h80C00000, "R7 flush positive");
        send(32'h81000000, 32'h00C00000, "R7 flush negative");
        idle(1);
        send(32'h7F7FFFFF, 32'h7F7FFFFF, "R8 overflow plus");
        send(32'hFF7FFFFF, 32'hFF7FFFFF, "R8 overflow minus");
        send(32'h7F7FFFFF, 32'h73000000, "R8 round overflow");
        send(32'h00000123, 32'h3F800000, "R9 denormal as zero");
        send(32'h80000001, 32'h80000000, "R9 negative zeros");
        send(32'h00000000, 32'h80000000, "R9 mixed zeros");
        send(32'h807FFFFF, 32'hC0000000, "R9 zero plus value");
        send(32'h7F800001, 32'h3F800000, "R10 nan input");
        send(32'h7F800000, 32'hFF800000, "R10 inf minus inf");
        send(32'hFF800000, 32'h3F800000, "R11 neg inf plus finite");
        send(32'h7F800000, 32'h7F800000, "R11 inf plus inf");
        send(32'h42000000, 32'h7F800000, "R11 finite plus inf");
        idle(3);

        for (int k = 0; k < 600; k++) begin
            int mode, ea, eb;
            logic [31:0] a, b;
            mode = int'($urandom % 4);
            ea = 1 + int'($urandom % 254);
            a  = pick(ea, 1'($urandom));
            case (mode)
                0: begin a = $urandom; b = $urandom; end
                1: begin
                    eb = ea + int'($urandom % 7) - 3;
                    if (eb < 1) eb = 1;
                    if (eb > 254) eb = 254;
                    b = pick(eb, 1'($urandom));
                end
                2: b = {~a[31], a[30:4], 4'($urandom)};
                default: begin
                    eb = ea - 20 - int'($urandom % 12);
                    if (eb < 1) eb = 1;
                    b = pick(eb, 1'($urandom));
                end
            endcase
            send(a, b, (mode == 2) ? "R7 random cancel" :
                       (mode == 3) ? "R4 random far gap" : "R3 random");
            if ((k % 9) == 0) idle(1);
        end
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule